// File: doc/BRIEF.md
# Memory Bank Chip-Select Decoder

This block sits between a bus master and a set of memory-timing machines. It keeps one configuration register and one compare mask for each of `NUM_BANKS` memory banks. For every bus request it finds the bank that owns the address. It then reports the bank's index and the kind of machine that must run the cycle, along with the bank's port width, error-checking mode and data-delay flag. The actual timing machines (SDRAM, general-purpose and user-programmable sequencers) are outside this block. They consume its decision one clock after the request.

A bank can be configured so that it refuses writes, hands its accesses to an external controller, or names a machine code that is not implemented. A write to a read-only bank raises a protection error and is not forwarded. A hit on an unimplemented machine code raises a select error instead of a request. When several valid banks cover the same address, the lowest-numbered bank wins. Software loads and reads back the registers through a simple write/read port.

Top module: `bank_cs_decoder`

## Requirements
- R1: Each bank configuration register uses this bit layout: bit 0 = valid, bit 1 = data delay, bit 4 = external controller, bits 7:5 = machine select, bit 8 = write protect, bits 10:9 = error-checking mode, bits 12:11 = port size, bits 31:15 = base. Bits 3:2 and 14:13 are held at zero and read back as zero. After reset, every register reads zero except bank 0, which reads 1 (valid set). Every mask reads back all ones (17'h1FFFF) in its low 17 bits, and its upper bits read zero.
- R2: A request hits bank i when bank i is valid and the request address bits 31:15 equal the base of bank i at every position where the mask of bank i is 1. Mask positions that are 0 are ignored in the compare.
- R3: A bank whose valid bit is 0 never produces a hit.
- R4: When more than one valid bank matches, `hit_bank` reports the lowest-numbered one, and all reported fields come from that bank.
- R5: On a hit, `mach_sel` carries the bank's 3-bit machine code. The codes are 000 general-purpose on the system bus, 001 general-purpose on the local bus, 010 SDRAM, and 100/101/110 user-programmable machines A/B/C. A hit on one of these codes, with no other condition blocking it, asserts `mach_req`. Codes 011 and 111 are reserved: a hit on a reserved code asserts `sel_err` and not `mach_req`.
- R6: A write that hits a bank with write protect set asserts `wp_err` and asserts neither `mach_req` nor `ext_req`. A read of the same bank is served normally.
- R7: A hit on a bank with the external-controller bit set asserts `ext_req` instead of `mach_req`, whatever its machine code, and it never asserts `sel_err`.
- R8: On a hit, `port_size` (00 = 64-bit, 01 = 8-bit, 10 = 16-bit, 11 = 32-bit), `chk_mode` (00 = off, 01 = parity, 10 = read-modify-write parity, 11 = ECC) and `beat_delay` carry the bank's fields.
- R9: Every output is registered and reflects the request presented at the previous rising clock edge. When no request was presented, or the request missed every bank, all outputs are zero.
- R10: `cfg_addr` is {bank index, select}: select 0 addresses the configuration register and select 1 addresses the mask. A write to a bank index of `NUM_BANKS` or above changes no register. A read of such an index returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | BANK_W+1 (5) | {bank index, select} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational register read data |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | ADDR_W (32) | Request address |
| hit | output | 1 | A valid bank claimed the request |
| hit_bank | output | BANK_W (4) | Index of the claiming bank |
| mach_sel | output | 3 | Machine code of the claiming bank |
| mach_req | output | 1 | Request forwarded to an internal machine |
| ext_req | output | 1 | Request forwarded to the external controller |
| port_size | output | 2 | Port width code of the claiming bank |
| chk_mode | output | 2 | Error-checking code of the claiming bank |
| beat_delay | output | 1 | Data beats of this access are delayed one cycle |
| wp_err | output | 1 | Write to a write-protected bank |
| sel_err | output | 1 | Hit on a reserved machine code |

## Verification
The assertions assume that `req_write` is meaningful only while `req_valid` is high. They also assume that the registers are not rewritten in the same cycle as a request that depends on them, because the decision uses the register contents at the request edge. The bench keeps to both rules: it issues configuration writes and bus requests in separate cycles, and it holds `req_valid` low between requests. Expected outputs come from a shadow copy of every register written. The bench walks a band of addresses above and below the programmed bases, so overlapping, masked, invalid, protected, external and reserved banks are all struck by both reads and writes.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;

    localparam int REG_W  = 32;
    localparam int BASE_W = 17;

    // Configuration register image, MSB first.
    typedef struct packed {
        logic [BASE_W-1:0] base;     // 31:15
        logic [1:0]        pad_hi;   // 14:13
        logic [1:0]        psize;    // 12:11
        logic [1:0]        chk;      // 10:9
        logic              wprot;    // 8
        logic [2:0]        msel;     // 7:5
        logic              ext;      // 4
        logic [1:0]        pad_lo;   // 3:2
        logic              dly;      // 1
        logic              vld;      // 0
    } bank_cfg_t;

    typedef enum logic [2:0] {
        MS_GP_SYS  = 3'b000,
        MS_GP_LOC  = 3'b001,
        MS_SDRAM   = 3'b010,
        MS_RSV_A   = 3'b011,
        MS_USER_A  = 3'b100,
        MS_USER_B  = 3'b101,
        MS_USER_C  = 3'b110,
        MS_RSV_B   = 3'b111
    } mach_code_e;

    function automatic logic msel_reserved(input logic [2:0] code);
        return (code == MS_RSV_A) || (code == MS_RSV_B);
    endfunction

    function automatic bank_cfg_t cfg_scrub(input logic [REG_W-1:0] raw);
        bank_cfg_t c;
        c        = bank_cfg_t'(raw);
        c.pad_hi = '0;
        c.pad_lo = '0;
        return c;
    endfunction

endpackage

// File: rtl/bankdec_regs.sv
module bankdec_regs
    import bankdec_pkg::*;
#(
    parameter int                NUM_BANKS = 10,
    parameter int                BANK_W    = 4,
    parameter logic [BASE_W-1:0] MASK_RST  = '1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_we,
    input  logic [BANK_W:0]                     cfg_addr,
    input  logic [REG_W-1:0]                    cfg_wdata,
    output logic [REG_W-1:0]                    cfg_rdata,
    output bank_cfg_t [NUM_BANKS-1:0]           cfg_o,
    output logic [NUM_BANKS-1:0][BASE_W-1:0]    mask_o
);

    typedef struct packed {
        bank_cfg_t [NUM_BANKS-1:0]           cfg;
        logic [NUM_BANKS-1:0][BASE_W-1:0]    mask;
    } regs_t;

    regs_t r_d, r_q;

    logic [BANK_W-1:0] sel_bank;
    logic              sel_mask;
    logic              sel_ok;

    assign sel_bank = cfg_addr[BANK_W:1];
    assign sel_mask = cfg_addr[0];
    assign sel_ok   = (int'(sel_bank) < NUM_BANKS);

    function automatic regs_t reset_image();
        regs_t img;
        for (int i = 0; i < NUM_BANKS; i++) begin
            img.cfg[i]     = '0;
            img.cfg[i].vld = (i == 0);
            img.mask[i]    = MASK_RST;
        end
        return img;
    endfunction

    always_comb begin
        r_d       = r_q;
        cfg_rdata = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (BANK_W'(i) == sel_bank) begin
                if (sel_mask) begin
                    cfg_rdata = REG_W'(r_q.mask[i]);
                    if (cfg_we) r_d.mask[i] = cfg_wdata[BASE_W-1:0];
                end else begin
                    cfg_rdata = r_q.cfg[i];
                    if (cfg_we) r_d.cfg[i] = cfg_scrub(cfg_wdata);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= reset_image();
        else        r_q <= r_d;
    end

    assign cfg_o  = r_q.cfg;
    assign mask_o = r_q.mask;

    assert_oor_write_ignored_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        (cfg_we && !sel_ok) |=> $stable(r_q)
    );

    assert_regs_hold_without_write_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(r_q)
    );

endmodule

// File: rtl/bankdec_match.sv
module bankdec_match
    import bankdec_pkg::*;
#(
    parameter int NUM_BANKS = 10,
    parameter int BANK_W    = 4
) (
    input  bank_cfg_t [NUM_BANKS-1:0]           cfg_i,
    input  logic [NUM_BANKS-1:0][BASE_W-1:0]    mask_i,
    input  logic [BASE_W-1:0]                   addr_hi,
    output logic                                hit_o,
    output logic [BANK_W-1:0]                   idx_o
);

    logic [NUM_BANKS-1:0] bank_hit;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cmp
        logic [BASE_W-1:0] diff;
        assign diff        = (addr_hi ^ cfg_i[g].base) & mask_i[g];
        assign bank_hit[g] = cfg_i[g].vld && (diff == '0);
    end

    // Scan from the top so the lowest matching index is the last to write.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (bank_hit[i]) begin
                hit_o = 1'b1;
                idx_o = BANK_W'(i);
            end
        end
    end

endmodule

// File: rtl/bankdec_route.sv
module bankdec_route
    import bankdec_pkg::*;
#(
    parameter int NUM_BANKS = 10,
    parameter int BANK_W    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic                         hit_i,
    input  logic [BANK_W-1:0]            idx_i,
    input  bank_cfg_t [NUM_BANKS-1:0]    cfg_i,
    output logic                         hit_o,
    output logic [BANK_W-1:0]            bank_o,
    output logic [2:0]                   msel_o,
    output logic                         mach_req_o,
    output logic                         ext_req_o,
    output logic [1:0]                   psize_o,
    output logic [1:0]                   chk_o,
    output logic                         dly_o,
    output logic                         wp_err_o,
    output logic                         sel_err_o
);

    typedef struct packed {
        logic              hit;
        logic [BANK_W-1:0] bank;
        logic [2:0]        msel;
        logic              mach_req;
        logic              ext_req;
        logic [1:0]        psize;
        logic [1:0]        chk;
        logic              dly;
        logic              wp_err;
        logic              sel_err;
    } route_t;

    route_t    o_d, o_q;
    bank_cfg_t pick;
    logic      blocked;

    always_comb begin
        pick = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (BANK_W'(i) == idx_i) pick = cfg_i[i];
        end
    end

    always_comb begin
        o_d     = '0;
        blocked = req_write && pick.wprot;
        if (req_valid && hit_i) begin
            o_d.hit    = 1'b1;
            o_d.bank   = idx_i;
            o_d.msel   = pick.msel;
            o_d.psize  = pick.psize;
            o_d.chk    = pick.chk;
            o_d.dly    = pick.dly;
            o_d.wp_err = blocked;
            if (!blocked) begin
                if (pick.ext)                     o_d.ext_req  = 1'b1;
                else if (msel_reserved(pick.msel)) o_d.sel_err  = 1'b1;
                else                              o_d.mach_req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign hit_o      = o_q.hit;
    assign bank_o     = o_q.bank;
    assign msel_o     = o_q.msel;
    assign mach_req_o = o_q.mach_req;
    assign ext_req_o  = o_q.ext_req;
    assign psize_o    = o_q.psize;
    assign chk_o      = o_q.chk;
    assign dly_o      = o_q.dly;
    assign wp_err_o   = o_q.wp_err;
    assign sel_err_o  = o_q.sel_err;

    assert_one_outcome_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        $onehot0({o_q.mach_req, o_q.ext_req, o_q.wp_err, o_q.sel_err})
    );

    assert_idle_without_request_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        !req_valid |=> !o_q.hit && !o_q.mach_req && !o_q.ext_req
    );

    assert_wp_only_on_write_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        o_q.wp_err |-> $past(req_write) && o_q.hit
    );

    assert_sel_err_reserved_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        o_q.sel_err |-> o_q.hit && msel_reserved(o_q.msel)
    );

    assert_req_needs_hit_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (o_q.mach_req || o_q.ext_req) |-> o_q.hit
    );

endmodule

// File: rtl/bank_cs_decoder.sv
module bank_cs_decoder
    import bankdec_pkg::*;
#(
    parameter int NUM_BANKS = 10,
    parameter int ADDR_W    = 32,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [BANK_W:0]      cfg_addr,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 hit,
    output logic [BANK_W-1:0]    hit_bank,
    output logic [2:0]           mach_sel,
    output logic                 mach_req,
    output logic                 ext_req,
    output logic [1:0]           port_size,
    output logic [1:0]           chk_mode,
    output logic                 beat_delay,
    output logic                 wp_err,
    output logic                 sel_err
);

    localparam int ADDR_HI_LSB = ADDR_W - BASE_W;

    bank_cfg_t [NUM_BANKS-1:0]           cfg;
    logic [NUM_BANKS-1:0][BASE_W-1:0]    mask;
    logic                                m_hit;
    logic [BANK_W-1:0]                   m_idx;
    logic [BASE_W-1:0]                   addr_hi;

    assign addr_hi = req_addr[ADDR_W-1:ADDR_HI_LSB];

    bankdec_regs #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_o     (cfg),
        .mask_o    (mask)
    );

    bankdec_match #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_match (
        .cfg_i   (cfg),
        .mask_i  (mask),
        .addr_hi (addr_hi),
        .hit_o   (m_hit),
        .idx_o   (m_idx)
    );

    bankdec_route #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .hit_i      (m_hit),
        .idx_i      (m_idx),
        .cfg_i      (cfg),
        .hit_o      (hit),
        .bank_o     (hit_bank),
        .msel_o     (mach_sel),
        .mach_req_o (mach_req),
        .ext_req_o  (ext_req),
        .psize_o    (port_size),
        .chk_o      (chk_mode),
        .dly_o      (beat_delay),
        .wp_err_o   (wp_err),
        .sel_err_o  (sel_err)
    );

    assert_hit_bank_in_range_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        hit |-> (int'(hit_bank) < NUM_BANKS)
    );

endmodule

// File: tb/sim_bank_cs_decoder.sv
module sim_bank_cs_decoder;

    localparam int NB = 10;
    localparam int BW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [BW:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        hit, mach_req, ext_req, beat_delay, wp_err, sel_err;
    logic [BW-1:0] hit_bank;
    logic [2:0]  mach_sel;
    logic [1:0]  port_size, chk_mode;

    int checks = 0;
    int errors = 0;

    logic [31:0] sh_cfg  [NB];
    logic [16:0] sh_mask [NB];

    always #4 clk = ~clk;

    bank_cs_decoder #(.NUM_BANKS(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .hit(hit), .hit_bank(hit_bank),
        .mach_sel(mach_sel), .mach_req(mach_req), .ext_req(ext_req),
        .port_size(port_size), .chk_mode(chk_mode), .beat_delay(beat_delay),
        .wp_err(wp_err), .sel_err(sel_err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic wr_reg(input int bank, input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = {BW'(bank), sel}; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (bank < NB) begin
            if (sel) sh_mask[bank] = d[16:0];
            else     sh_cfg[bank]  = d & 32'hFFFF_9FF3;
        end
    endtask

    task automatic rd_all(input string tag);
        for (int b = 0; b < 16; b++) begin
            for (int s = 0; s < 2; s++) begin
                logic [31:0] e;
                if (b >= NB)    e = '0;
                else if (s == 1) e = {15'b0, sh_mask[b]};
                else            e = sh_cfg[b];
                @(negedge clk);
                cfg_addr = {BW'(b), s[0]};
                #1;
                chk(tag, $sformatf("readback bank %0d sel %0d", b, s), cfg_rdata, e);
            end
        end
    endtask

    task automatic do_req(input logic [31:0] a, input logic w, input string tag);
        logic e_hit, e_mreq, e_ext, e_wp, e_serr, e_dly;
        logic [3:0] e_idx;
        logic [2:0] e_ms;
        logic [1:0] e_ps, e_ck;
        logic [31:0] c;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        e_hit = 0; e_idx = 0; e_mreq = 0; e_ext = 0; e_wp = 0; e_serr = 0;
        e_ms = 0; e_ps = 0; e_ck = 0; e_dly = 0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (sh_cfg[i][0] && (((a[31:15] ^ sh_cfg[i][31:15]) & sh_mask[i]) == 17'd0)) begin
                e_hit = 1; e_idx = 4'(i);
            end
        end
        if (e_hit) begin
            c     = sh_cfg[e_idx];
            e_ms  = c[7:5]; e_ps = c[12:11]; e_ck = c[10:9]; e_dly = c[1];
            e_wp  = w & c[8];
            if (!e_wp) begin
                if (c[4])                         e_ext  = 1;
                else if (e_ms == 3 || e_ms == 7)  e_serr = 1;
                else                              e_mreq = 1;
            end
        end
        chk({tag, "/R2"}, $sformatf("hit @%h w%0d", a, w), 32'(hit), 32'(e_hit));
        chk({tag, "/R4"}, $sformatf("bank @%h", a), 32'(hit_bank), 32'(e_idx));
        chk({tag, "/R5"}, $sformatf("msel @%h", a), 32'(mach_sel), 32'(e_ms));
        chk({tag, "/R5"}, $sformatf("mach_req @%h w%0d", a, w), 32'(mach_req), 32'(e_mreq));
        chk({tag, "/R5"}, $sformatf("sel_err @%h", a), 32'(sel_err), 32'(e_serr));
        chk({tag, "/R7"}, $sformatf("ext_req @%h w%0d", a, w), 32'(ext_req), 32'(e_ext));
        chk({tag, "/R6"}, $sformatf("wp_err @%h w%0d", a, w), 32'(wp_err), 32'(e_wp));
        chk({tag, "/R8"}, $sformatf("fields @%h", a),
            {27'b0, port_size, chk_mode, beat_delay}, {27'b0, e_ps, e_ck, e_dly});
    endtask

    task automatic chk_idle(input string tag);
        @(negedge clk);
        chk(tag, "idle outputs",
            {20'b0, hit, hit_bank, mach_sel, mach_req, ext_req, wp_err, sel_err},
            32'b0);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < NB; i++) begin
            sh_cfg[i]  = (i == 0) ? 32'h1 : 32'h0;
            sh_mask[i] = 17'h1FFFF;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset image; R10: out-of-range indices read zero
        rd_all("R1");
        // R9: no request gives quiet outputs
        chk_idle("R9");
        // R2: after reset only bank 0 (base 0) claims addresses
        do_req(32'h0000_1234, 1'b0, "R2");
        do_req(32'h0000_8000, 1'b1, "R2");
        chk_idle("R9");

        // Program banks: base 0x100+b, fields derived from b
        for (int b = 0; b < NB; b++) begin
            logic [31:0] d;
            d = '0;
            d[31:15] = 17'h100 + 17'(b);
            d[12:11] = 2'(b);
            d[10:9]  = 2'(b >> 1);
            d[8]     = (b == 2 || b == 5);
            d[7:5]   = 3'(b);
            d[4]     = (b == 6);
            d[1]     = b[0];
            d[0]     = (b != 8);
            d[3:2]   = 2'b11;     // reserved bits must not stick
            d[14:13] = 2'b11;
            wr_reg(b, 1'b0, d);
        end
        rd_all("R1");

        // R10: writes to banks beyond the top change nothing
        wr_reg(12, 1'b0, 32'hFFFF_FFFF);
        wr_reg(15, 1'b1, 32'hFFFF_FFFF);
        rd_all("R10");

        // R3: bank 8 matches by base but is invalid
        do_req({17'h108, 15'h0042}, 1'b0, "R3");
        chk("R3", "invalid bank no hit", 32'(hit), 32'h0);

        // Per-bank read and write (R5 codes, R6 protect, R7 external, R8 fields)
        for (int b = 0; b < NB; b++) begin
            do_req({17'h100 + 17'(b), 15'(b * 37)}, 1'b0, "SWEEP");
            do_req({17'h100 + 17'(b), 15'(b * 91)}, 1'b1, "SWEEP");
        end

        // R4: bank 9 aliases bank 2; lower index wins
        wr_reg(9, 1'b0, {17'h102, 15'h0021});
        do_req({17'h102, 15'h7FFF}, 1'b0, "R4");
        chk("R4", "alias resolves to bank 2", 32'(hit_bank), 32'd2);

        // R2: bank 4 mask ignores low 4 base bits -> covers 0x100..0x10F
        wr_reg(4, 1'b1, 32'h0001_FFF0);
        for (int u = 17'h0F8; u < 17'h118; u++) begin
            do_req({17'(u), 15'h0155}, 1'b0, "MASK");
            do_req({17'(u), 15'h2AAA}, 1'b1, "MASK");
        end
        do_req({17'h10C, 15'h0}, 1'b0, "R2");
        chk("R2", "masked compare selects bank 4", 32'(hit_bank), 32'd4);

        // R3: invalidate bank 0, its address now falls to masked bank 4
        wr_reg(0, 1'b0, {17'h100, 15'h0});
        do_req({17'h100, 15'h0}, 1'b0, "R3");
        chk("R3", "cleared valid skips bank 0", 32'(hit_bank), 32'd4);
        chk_idle("R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule